// File: doc/BRIEF.md
# Alternating-Edge Windowed Watchdog

This block holds the supply on only while the processor keeps toggling a watchdog pin at a steady rate. The pin is brought into the clock domain through a flop synchroniser. A start-up arm signal opens the block: the first rising edge seen while armed starts monitoring. After that, every pin transition must land inside a window measured from the previous accepted transition. A transition that comes too early is fatal, and so is a window that closes with no transition. Either one raises a shutdown request, and that request stays high until reset.

Time is measured in window units. One unit is a fixed number of pulses on a free-running timebase tick, divided down by an internal prescaler. The prescaler restarts on every accepted transition, so each window begins on a unit boundary. The lower bound `T1_UNITS` and the upper bound `T2_UNITS` are parameters in units. A real system sets them to about 0.36 s and 2.86 s. A simulation uses small values.

Top module: `wdog_window_mon`

## Requirements
- R1: After reset `shutdown_o` is 0. While monitoring has not started and `arm_i` is 0, pin transitions of either polarity have no effect on `shutdown_o`.
- R2: With `arm_i` = 1 and monitoring not started, a rising pin transition starts monitoring. It does not raise `shutdown_o`, and it opens the first window.
- R3: With `arm_i` = 1 and monitoring not started, a falling pin transition as the first transition raises `shutdown_o`. A change on `wd_pin_i` reaches `shutdown_o` three clock edges later: two synchroniser stages, then the state register.
- R4: During monitoring, a transition seen while fewer than `T1_UNITS` units have passed since the last accepted transition raises `shutdown_o`.
- R5: During monitoring, a transition seen after at least `T1_UNITS` units, and no later than the clock on which the `T2_UNITS`-th unit would complete, is accepted. It restarts both the unit count and the prescaler, so a regular toggle keeps the block quiet for any length of time.
- R6: If `T2_UNITS` units complete with no transition, `shutdown_o` rises on the clock where the last unit completes. With a constant tick that clock is `PRESC_DIV*T2_UNITS` cycles after the accepted transition.
- R7: Once `shutdown_o` is 1 it stays 1, whatever the pin, arm and tick inputs do, until `rst_ni` is asserted.
- R8: A unit completes after `PRESC_DIV` clocks on which `tick_i` is 1. While `tick_i` is 0 no time passes: there is no timeout, and any transition counts as early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wd_pin_i | input | 1 | Asynchronous watchdog pin from the processor |
| arm_i | input | 1 | Start-up timer running; allows monitoring to begin |
| tick_i | input | 1 | Timebase tick, one clock wide per pulse |
| shutdown_o | output | 1 | Sticky power-down request |

## Verification
A pin change driven on a falling clock edge first shows at the state register on the third rising edge that follows. The bench therefore samples `shutdown_o` half a cycle after that edge. For the first-falling-edge case it also samples one cycle earlier and expects 0 there. With `tick_i` held high and a prescale of 2, the shortest accepted gap between pin changes is `2*T1_UNITS+1` clocks and the longest is `2*T2_UNITS`. The vector table places its gaps on both sides of each bound. The timeout test expects 0 after 22 clocks and 1 after 23, counted from the opening rising change. That is the three-edge latency plus `2*T2_UNITS` cycles.

// File: rtl/wdm_pkg.sv
package wdm_pkg;
  typedef enum logic [1:0] {
    WD_IDLE = 2'd0,
    WD_RUN  = 2'd1,
    WD_TRIP = 2'd2
  } wd_state_e;
endpackage

// File: rtl/wdm_sync.sv
module wdm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;

  // R3
  one_polarity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));
endmodule

// File: rtl/wdm_presc.sv
module wdm_presc #(
  parameter int unsigned DIV = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic unit_o
);
  generate
    if (DIV <= 1) begin : g_pass
      assign unit_o = tick_i;
    end else begin : g_div
      localparam int unsigned PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                       cnt_q <= '0;
        else if (clr_i)                    cnt_q <= '0;
        else if (tick_i && cnt_q == LAST)  cnt_q <= '0;
        else if (tick_i)                   cnt_q <= cnt_q + 1'b1;
      end

      assign unit_o = tick_i && (cnt_q == LAST);

      // R8
      presc_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LAST);
      // R8
      presc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !clr_i) |=> $stable(cnt_q));
    end
  endgenerate

  // R8
  unit_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_o |-> tick_i);
endmodule

// File: rtl/wdm_window.sv
module wdm_window
  import wdm_pkg::*;
#(
  parameter int unsigned T1_UNITS = 360,
  parameter int unsigned T2_UNITS = 2860
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic rise_i,
  input  logic fall_i,
  input  logic unit_i,
  output logic restart_o,
  output logic trip_o
);
  localparam int unsigned CW = $clog2(T2_UNITS + 1);
  localparam logic [CW-1:0] T1_C  = CW'(T1_UNITS);
  localparam logic [CW-1:0] T2M_C = CW'(T2_UNITS - 1);

  wd_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          edge_w;

  assign edge_w = rise_i | fall_i;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    restart_o = 1'b0;
    unique case (state_q)
      WD_IDLE: begin
        if (arm_i && rise_i) begin
          state_d   = WD_RUN;
          cnt_d     = '0;
          restart_o = 1'b1;
        end else if (arm_i && fall_i) begin
          state_d = WD_TRIP;
        end
      end
      WD_RUN: begin
        if (edge_w) begin
          if (cnt_q >= T1_C) begin
            cnt_d     = '0;
            restart_o = 1'b1;
          end else begin
            state_d = WD_TRIP;  // too early
          end
        end else if (unit_i) begin
          if (cnt_q == T2M_C) state_d = WD_TRIP;  // window closed
          else                cnt_d   = cnt_q + 1'b1;
        end
      end
      default: state_d = WD_TRIP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WD_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign trip_o = (state_q == WD_TRIP);

  // R7
  sticky_trip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_o |=> trip_o);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WD_IDLE && !arm_i) |=> !trip_o);
  // R4
  early_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WD_RUN && edge_w && cnt_q < T1_C) |=> trip_o);
  // R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= T2M_C);
  // R5
  accept_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WD_RUN && edge_w && cnt_q >= T1_C) |=> (cnt_q == '0 && !trip_o));
endmodule

// File: rtl/wdog_window_mon.sv
module wdog_window_mon #(
  parameter int unsigned PRESC_DIV   = 32,
  parameter int unsigned T1_UNITS    = 360,
  parameter int unsigned T2_UNITS    = 2860,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wd_pin_i,
  input  logic arm_i,
  input  logic tick_i,
  output logic shutdown_o
);
  logic rise_w, fall_w, unit_w, restart_w;

  wdm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (wd_pin_i),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  wdm_presc #(.DIV(PRESC_DIV)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .clr_i  (restart_w),
    .unit_o (unit_w)
  );

  wdm_window #(.T1_UNITS(T1_UNITS), .T2_UNITS(T2_UNITS)) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (arm_i),
    .rise_i    (rise_w),
    .fall_i    (fall_w),
    .unit_i    (unit_w),
    .restart_o (restart_w),
    .trip_o    (shutdown_o)
  );
endmodule

// File: tb/sim_wdog_window_mon.sv
`timescale 1ns/1ps
module sim_wdog_window_mon;
  localparam int DIV   = 2;
  localparam int T1    = 4;
  localparam int T2    = 10;
  localparam int MIN_G = DIV*T1 + 1;
  localparam int MAX_G = DIV*T2;
  localparam int NV    = 6;
  localparam int GAPS [NV] = '{MIN_G-1, MIN_G, MIN_G+5, MAX_G, MAX_G+1, 3};
  localparam bit EXPS [NV] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0, pin = 1'b0, arm = 1'b0, tick = 1'b1;
  logic sd;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_window_mon #(.PRESC_DIV(DIV), .T1_UNITS(T1), .T2_UNITS(T2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wd_pin_i(pin), .arm_i(arm),
    .tick_i(tick), .shutdown_o(sd)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: shutdown_o=%b expected %b", req, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pin = 1'b0; arm = 1'b0; tick = 1'b1;
    wait_n(2);
    rst_n = 1'b1;
    wait_n(1);
  endtask

  task automatic start_run();
    arm = 1'b1;
    wait_n(3);
    pin = 1'b1;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1 reset state, unarmed transitions ignored
    do_reset();
    chk("R1 reset", sd, 1'b0);
    for (int i = 0; i < 6; i++) begin pin = ~pin; wait_n(2); end
    pin = 1'b0; wait_n(5);
    chk("R1 unarmed edges", sd, 1'b0);

    // Vector table: gap between opening rise and next change
    for (int v = 0; v < NV; v++) begin
      do_reset();
      start_run();
      wait_n(GAPS[v]);
      pin = 1'b0;
      wait_n(3);
      chk(EXPS[v] ? "R4/R6 gap trips" : "R2/R5 gap accepted", sd, EXPS[v]);
    end

    // R3 first transition falling, exact latency
    do_reset();
    pin = 1'b1; wait_n(4);
    chk("R1 rise without arm", sd, 1'b0);
    arm = 1'b1; wait_n(1);
    pin = 1'b0;
    wait_n(2);
    chk("R3 before latency", sd, 1'b0);
    wait_n(1);
    chk("R3 first falling", sd, 1'b1);

    // R6 timeout exact cycle
    do_reset();
    start_run();
    wait_n(2 + MAX_G);
    chk("R6 one before timeout", sd, 1'b0);
    wait_n(1);
    chk("R6 timeout", sd, 1'b1);

    // R5 chain of accepted transitions, then early one (R4)
    do_reset();
    start_run();
    for (int i = 0; i < 5; i++) begin wait_n(MIN_G + 3); pin = ~pin; end
    wait_n(3);
    chk("R5 chain reloads", sd, 1'b0);
    wait_n(MIN_G - 1 - 3);
    pin = ~pin;
    wait_n(3);
    chk("R4 early after chain", sd, 1'b1);

    // R7 sticky
    for (int i = 0; i < 3; i++) begin wait_n(MIN_G + 2); pin = ~pin; end
    arm = 1'b0; tick = 1'b0;
    wait_n(5);
    chk("R7 sticky", sd, 1'b1);
    do_reset();
    chk("R7 reset clears", sd, 1'b0);

    // R8 no tick, no time passes
    do_reset();
    tick = 1'b0;
    start_run();
    wait_n(3 * MAX_G);
    chk("R8 no timeout without tick", sd, 1'b0);
    pin = 1'b0;
    wait_n(3);
    chk("R8 edge early without tick", sd, 1'b1);

    // R8 slow tick stretches window
    do_reset();
    start_run();
    tick = 1'b0;
    wait_n(MAX_G + 5);
    pin = 1'b0;
    wait_n(3);
    chk("R8 window frozen, edge early", sd, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule